// File: doc/BRIEF.md
# Serial CRC Frame Check Generator

This block produces the frame check sequence for a message that arrives one bit per clock, most significant bit first. An n-stage shift register holds the running remainder. Its feedback is the incoming bit XORed with the top stage, and XOR taps are placed by the generator polynomial. Because the message bit is injected at the high end, the division by G(X) already accounts for the n trailing zeros. When the last bit is taken, the register holds the remainder at once, with no flush cycles.

The same register then shifts the remainder out on a serial output, most significant bit first, with its feedback forced to zero. The check bits can therefore follow the message directly on the line. A one-cycle done pulse closes the frame. A start pulse clears the register at any time and opens a new frame.

Top module: `crcgen_serial`

## Requirements
- R1: While reset is asserted and after its release, fcs_vld_o, fcs_bit_o and done_o are 0 and the remainder register is all zeros.
- R2: A cycle with start_i high clears the remainder register and begins a new message phase, whatever phase the block was in (including mid-message and mid-drain). Bit inputs sampled in that same cycle are ignored.
- R3: In the message phase a bit is taken only in a cycle with bit_vld_i high. Cycles with bit_vld_i low leave the register unchanged, whatever bit_i and bit_last_i carry.
- R4: For each accepted bit, feedback = bit_i XOR top stage. The register shifts one place toward the top, stage 0 receives the feedback, and stage i (0 < i < n) is additionally XORed with the feedback when coefficient i of the generator is 1. After the bit flagged by bit_last_i, the register holds the remainder of X^n·M(X) divided by G(X).
- R5: The cycle after the last bit is accepted, fcs_vld_o rises and stays high for exactly n consecutive cycles. In each of these cycles fcs_bit_o carries one remainder bit, from coefficient n-1 down to coefficient 0.
- R6: During the output phase the feedback is zero and the register shifts toward the top with a 0 entering stage 0. In the output and idle phases, bit_vld_i, bit_i and bit_last_i have no effect.
- R7: done_o is high for exactly one cycle: the cycle right after the n-th output bit. It is not raised if start_i arrives in the final output cycle.
- R8: With n=5 and generator 100111, the message 10000000 yields the output sequence 1,1,0,1,0.
- R9: With n=4 and generator 11001, the message 11100110 yields the output sequence 0,1,1,0.
- R10: A one-bit message (bit_last_i set on the first accepted bit) is handled. With a 1 bit, the output equals the low n coefficients of the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear the remainder and open a new frame |
| bit_vld_i | input | 1 | bit_i and bit_last_i are valid this cycle |
| bit_i | input | 1 | Message bit, most significant first |
| bit_last_i | input | 1 | Marks the final message bit |
| fcs_bit_o | output | 1 | Serial check bit, most significant first |
| fcs_vld_o | output | 1 | fcs_bit_o carries a check bit |
| done_o | output | 1 | One-cycle pulse after the last check bit |

## Verification
The bench builds two copies side by side from the same stimulus. One has n=5 with generator 100111, and the other has n=4 with generator 11001. The pair brings both hand-worked vectors within reach, each on its own width. It also exposes any logic that silently depends on a fixed width or a fixed tap set, because the two copies must disagree on the same message in exactly the way long division predicts. Random lengths from one bit upward, idle gaps, noise during the output phase, and restarts mid-message and mid-output are run on both copies at once.

// File: rtl/crcgen_pkg.sv
package crcgen_pkg;

  typedef enum logic [1:0] {
    CG_IDLE  = 2'd0,
    CG_MSG   = 2'd1,
    CG_DRAIN = 2'd2
  } cg_state_e;

  function automatic int cg_cnt_width(input int stages);
    return (stages > 1) ? $clog2(stages) : 1;
  endfunction

endpackage

// File: rtl/crcgen_ctrl.sv
module crcgen_ctrl
  import crcgen_pkg::*;
#(
  parameter int CRC_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_last_i,
  output logic clr_o,
  output logic take_o,
  output logic drain_o,
  output logic idle_o,
  output logic done_o
);

  localparam int CNT_W = cg_cnt_width(CRC_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CRC_W - 1);

  cg_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             msg_end;
  logic             drain_end;

  assign clr_o     = start_i;
  assign take_o    = (state_q == CG_MSG) && bit_vld_i && !start_i;
  assign drain_o   = (state_q == CG_DRAIN);
  assign idle_o    = (state_q == CG_IDLE);
  assign msg_end   = take_o && bit_last_i;
  assign drain_end = drain_o && (cnt_q == CNT_LAST);
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CG_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= CG_MSG;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          CG_MSG: begin
            if (msg_end) begin
              state_q <= CG_DRAIN;
              cnt_q   <= '0;
            end
          end
          CG_DRAIN: begin
            if (drain_end) begin
              state_q <= CG_IDLE;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= CG_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/crcgen_shreg.sv
module crcgen_shreg #(
  parameter int               CRC_W = 5,
  parameter logic [CRC_W:0]   POLY  = 6'b100111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             drain_i,
  input  logic             bit_i,
  output logic             msb_o,
  output logic             fb_o,
  output logic [CRC_W-1:0] rem_o
);

  logic [CRC_W-1:0] stage_q;
  logic [CRC_W-1:0] stage_nxt;
  logic             fb;

  // feedback is gated off outside the message phase
  assign fb = take_i ? (bit_i ^ stage_q[CRC_W-1]) : 1'b0;

  assign stage_nxt[0] = fb;
  for (genvar gi = 1; gi < CRC_W; gi++) begin : g_stage
    if (POLY[gi]) begin : g_tap
      assign stage_nxt[gi] = stage_q[gi-1] ^ fb;
    end else begin : g_plain
      assign stage_nxt[gi] = stage_q[gi-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (clr_i) begin
      stage_q <= '0;
    end else if (take_i || drain_i) begin
      stage_q <= stage_nxt;
    end
  end

  assign msb_o = stage_q[CRC_W-1];
  assign fb_o  = fb;
  assign rem_o = stage_q;

endmodule

// File: rtl/crcgen_serial.sv
module crcgen_serial #(
  parameter int             CRC_W = 5,
  parameter logic [CRC_W:0] POLY  = 6'b100111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic bit_last_i,
  output logic fcs_bit_o,
  output logic fcs_vld_o,
  output logic done_o
);

  logic             clr_w;
  logic             take_w;
  logic             drain_w;
  logic             idle_w;
  logic             fb_w;
  logic             msb_w;
  logic [CRC_W-1:0] rem_w;

  crcgen_ctrl #(.CRC_W(CRC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .bit_vld_i (bit_vld_i),
    .bit_last_i(bit_last_i),
    .clr_o     (clr_w),
    .take_o    (take_w),
    .drain_o   (drain_w),
    .idle_o    (idle_w),
    .done_o    (done_o)
  );

  crcgen_shreg #(.CRC_W(CRC_W), .POLY(POLY)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_w),
    .take_i (take_w),
    .drain_i(drain_w),
    .bit_i  (bit_i),
    .msb_o  (msb_w),
    .fb_o   (fb_w),
    .rem_o  (rem_w)
  );

  assign fcs_bit_o = msb_w;
  assign fcs_vld_o = drain_w;

endmodule

// File: rtl/crcgen_checker.sv
module crcgen_checker #(
  parameter int CRC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             bit_vld_i,
  input logic             bit_i,
  input logic             bit_last_i,
  input logic             fcs_vld_o,
  input logic             done_o,
  input logic             take,
  input logic             drain,
  input logic             idle,
  input logic [CRC_W-1:0] rem
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (rem == '0) && !fcs_vld_o) else $error("start did not clear"); // R2

  AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !drain && !start_i) |=> $stable(rem)) else $error("register moved without a bit"); // R3

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle || drain) |-> !take) else $error("bit taken outside message phase"); // R6

  AST_FEEDBACK_IN: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rem[0] == $past(bit_i ^ rem[CRC_W-1])) else $error("feedback mismatch"); // R4

  AST_DRAIN_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !start_i) |=> rem[0] == 1'b0) else $error("feedback not gated"); // R6

  AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bit_last_i) |=> fcs_vld_o) else $error("output phase late"); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R7

  AST_DONE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(fcs_vld_o) && !fcs_vld_o)) else $error("done not after output"); // R7

  AST_VLD_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !fcs_vld_o) else $error("output valid while idle"); // R6

  AST_BIT_VLD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({bit_vld_i, start_i})) else $error("control input unknown"); // R3

endmodule

bind crcgen_serial crcgen_checker #(.CRC_W(CRC_W)) u_crcgen_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .bit_vld_i (bit_vld_i),
  .bit_i     (bit_i),
  .bit_last_i(bit_last_i),
  .fcs_vld_o (fcs_vld_o),
  .done_o    (done_o),
  .take      (take_w),
  .drain     (drain_w),
  .idle      (idle_w),
  .rem       (rem_w)
);

// File: tb/crc_lane.sv
module crc_lane #(
  parameter int         N = 5,
  parameter logic [N:0] G = 6'b100111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         vld,
  input  logic         bt,
  input  logic         last,
  output int           n_chk,
  output int           n_fail,
  output int           n_done,
  output logic [N-1:0] cap,
  output logic [N-1:0] exp_fcs,
  output logic         o_vld,
  output logic         o_bit,
  output logic         o_done
);

  crcgen_serial #(.CRC_W(N), .POLY(G)) i_crcgen_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .bit_vld_i (vld),
    .bit_i     (bt),
    .bit_last_i(last),
    .fcs_bit_o (o_bit),
    .fcs_vld_o (o_vld),
    .done_o    (o_done)
  );

  // plain long division of the message padded with N zeros
  function automatic logic [N-1:0] long_div(input bit m[$]);
    bit w[$];
    logic [N-1:0] r;
    w = m;
    repeat (N) w.push_back(1'b0);
    for (int i = 0; i < m.size(); i++)
      if (w[i])
        for (int j = 0; j <= N; j++) w[i+j] = w[i+j] ^ G[N-j];
    for (int j = 0; j < N; j++) r[N-1-j] = w[m.size()+j];
    return r;
  endfunction

  bit msg_q[$];
  bit fcs_q[$];
  int mode;       // 0 idle, 1 message, 2 output
  bit exp_done;
  int frame_id;
  int seen_id;

  initial begin
    mode = 0; exp_done = 0; frame_id = 0; seen_id = 0;
    n_chk = 0; n_fail = 0; n_done = 0; cap = '0; exp_fcs = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      msg_q.delete(); fcs_q.delete(); mode = 0; exp_done = 0;
    end else begin
      exp_done = 0;
      if (start) begin
        msg_q.delete(); fcs_q.delete(); mode = 1; frame_id++;
      end else if (mode == 1) begin
        if (vld) begin
          msg_q.push_back(bt);
          if (last) begin
            exp_fcs = long_div(msg_q);
            for (int j = N - 1; j >= 0; j--) fcs_q.push_back(exp_fcs[j]);
            mode = 2;
          end
        end
      end else if (mode == 2) begin
        void'(fcs_q.pop_front());
        if (fcs_q.size() == 0) begin
          mode = 0; exp_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (frame_id != seen_id) begin
      cap = '0; n_done = 0; seen_id = frame_id;
    end
    n_chk++;
    if (o_vld !== (mode == 2)) begin
      n_fail++;
      $display("FAIL R5 n=%0d fcs_vld got %b expected %b", N, o_vld, (mode == 2));
    end else if (mode == 2 && o_bit !== fcs_q[0]) begin
      n_fail++;
      $display("FAIL R4 n=%0d fcs_bit got %b expected %b", N, o_bit, fcs_q[0]);
    end else if (o_done !== exp_done) begin
      n_fail++;
      $display("FAIL R7 n=%0d done got %b expected %b", N, o_done, exp_done);
    end
    if (o_vld) cap = (cap << 1) | N'(o_bit);
    if (o_done) n_done++;
  end

endmodule

// File: tb/test_crcgen_serial.sv
module test_crcgen_serial;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vld = 1'b0, bt = 1'b0, last = 1'b0;

  int l5_chk, l5_fail, l5_done, l4_chk, l4_fail, l4_done;
  logic [4:0] l5_cap, l5_exp;
  logic [3:0] l4_cap, l4_exp;
  logic l5_vld, l5_bit, l5_dn, l4_vld, l4_bit, l4_dn;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  crc_lane #(.N(5), .G(6'b100111)) u_lane5 (
    .clk(clk), .rst_n(rst_n), .start(start), .vld(vld), .bt(bt), .last(last),
    .n_chk(l5_chk), .n_fail(l5_fail), .n_done(l5_done), .cap(l5_cap), .exp_fcs(l5_exp),
    .o_vld(l5_vld), .o_bit(l5_bit), .o_done(l5_dn));

  crc_lane #(.N(4), .G(5'b11001)) u_lane4 (
    .clk(clk), .rst_n(rst_n), .start(start), .vld(vld), .bt(bt), .last(last),
    .n_chk(l4_chk), .n_fail(l4_fail), .n_done(l4_done), .cap(l4_cap), .exp_fcs(l4_exp),
    .o_vld(l4_vld), .o_bit(l4_bit), .o_done(l4_dn));

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + l5_chk + l4_chk, n_fail + l5_fail + l4_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog got %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic go_idle();
    start = 1'b0; vld = 1'b0; bt = 1'b0; last = 1'b0;
  endtask

  task automatic run_frame(input bit msg[$], input int gap_pct, input bit junk, input bit cut);
    @(negedge clk);
    start = 1'b1; vld = 1'b1; bt = 1'b1; last = 1'b1;   // ignored (R2)
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < msg.size(); i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        vld = 1'b0; bt = 1'($urandom); last = 1'($urandom);
        @(negedge clk);
      end
      vld = 1'b1; bt = msg[i]; last = (i == msg.size() - 1);
      @(negedge clk);
    end
    if (cut) begin
      go_idle();
      @(negedge clk);
    end else begin
      for (int c = 0; c < 9; c++) begin
        if (junk) begin
          vld = 1'($urandom); bt = 1'($urandom); last = 1'($urandom);
        end else go_idle();
        @(negedge clk);
      end
      go_idle();
      #1;
    end
  endtask

  task automatic check_frame(input string tag);
    check(tag, 8'(l5_cap), 8'(l5_exp));
    check(tag, 8'(l4_cap), 8'(l4_exp));
    check("R7 done count n=5", 8'(l5_done), 8'd1);
    check("R7 done count n=4", 8'(l4_done), 8'd1);
  endtask

  function automatic void rand_msg(ref bit q[$], input int len);
    q.delete();
    for (int i = 0; i < len; i++) q.push_back(1'($urandom));
  endfunction

  initial begin
    bit m[$];
    go_idle();
    repeat (3) @(negedge clk);
    #1;
    check("R1 outputs in reset", {2'b00, l5_vld, l5_bit, l5_dn, l4_vld, l4_bit, l4_dn}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 outputs after reset", {2'b00, l5_vld, l5_bit, l5_dn, l4_vld, l4_bit, l4_dn}, 8'd0);

    // R6: bits offered while idle, with no start
    for (int c = 0; c < 10; c++) begin
      vld = 1'b1; bt = 1'($urandom); last = 1'($urandom);
      @(negedge clk); #1;
      check("R6 idle input ignored", {6'd0, l5_vld, l4_vld}, 8'd0);
    end
    go_idle();

    // R8 and R9 hand vectors
    m = '{1, 0, 0, 0, 0, 0, 0, 0};
    run_frame(m, 0, 0, 0);
    check("R8 fcs 11010", 8'(l5_cap), 8'b11010);
    check_frame("R4 n=4 on R8 message");
    m = '{1, 1, 1, 0, 0, 1, 1, 0};
    run_frame(m, 0, 0, 0);
    check("R9 fcs 0110", 8'(l4_cap), 8'b0110);
    check_frame("R4 n=5 on R9 message");

    // R10 single bit messages
    m = '{1};
    run_frame(m, 0, 0, 0);
    check("R10 single 1 n=5", 8'(l5_cap), 8'b00111);
    check("R10 single 1 n=4", 8'(l4_cap), 8'b1001);
    m = '{0};
    run_frame(m, 0, 0, 0);
    check("R10 single 0 n=5", 8'(l5_cap), 8'd0);
    check_frame("R10 single 0");

    // R3 gaps with noise on the bit lines
    for (int f = 0; f < 6; f++) begin
      rand_msg(m, 3 + int'($urandom_range(20)));
      run_frame(m, 40, 0, 0);
      check_frame("R3 gapped frame");
    end

    // R6 noise during output and idle phases
    for (int f = 0; f < 4; f++) begin
      rand_msg(m, 2 + int'($urandom_range(15)));
      run_frame(m, 10, 1, 0);
      check_frame("R6 noise in output phase");
    end

    // R2 restart mid-message, then restart mid-output
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      vld = 1'b1; bt = 1'($urandom); last = 1'b0;
      @(negedge clk);
    end
    go_idle();
    rand_msg(m, 12);
    run_frame(m, 0, 0, 0);
    check_frame("R2 restart mid-message");
    rand_msg(m, 9);
    run_frame(m, 0, 0, 1);
    rand_msg(m, 7);
    run_frame(m, 0, 0, 0);
    check_frame("R2 restart mid-output");

    // R4 R5 random lengths
    for (int f = 0; f < 30; f++) begin
      rand_msg(m, 1 + int'($urandom_range(39)));
      run_frame(m, 20, f[0], 0);
      check_frame("R4 R5 random frame");
    end

    repeat (4) @(negedge clk);
    report();
  end

endmodule